// File: doc/BRIEF.md
# Bus Request Stretcher for a Legacy Arbiter

This block sits between a host processor and an older external bus arbiter. Both sides use active-low request and grant lines. The host raises its request only briefly. It may also let the request go while its transaction is still running, which invites a new arbitration round to overlap the current one. The legacy arbiter needs something different: after it grants the bus, the request must stay low until the transaction is over.

The bridge turns the host's short request into one legacy request that lasts the whole transaction. It passes the legacy grant back to the host only while the bus is owned and no translated transaction is running. A new host request that arrives during a transaction gets no grant until the transaction has finished. The bridge then drops the legacy request for at least one cycle, so the arbiter sees a distinct new request. The arbitration policy itself remains in the external arbiter. Everything runs on the rising edge of a single clock.

Top module: `arb_req_stretcher`

## Requirements
- R1: While `rst_n` is low, `leg_req_n` and `host_bg_n` are both high, whatever the other inputs are. After reset the bridge is idle.
- R2: When the bridge is idle and `host_br_n` is sampled low at a rising edge, `leg_req_n` goes low right after that edge.
- R3: `host_bg_n` is low only in a cycle where the bus has been won (the legacy grant was sampled low while requesting), `leg_grant_n` is currently low, and no transaction is active.
- R4: When `host_ts_n` is sampled low while `host_bg_n` is low, a transaction starts. From then on `leg_req_n` stays low on every edge until `txn_done` is sampled high, even if `host_br_n` returns high.
- R5: When `txn_done` is sampled high during a transaction, `leg_req_n` goes high right after that edge. It stays high for at least one cycle before any new request.
- R6: While a transaction is active, `host_bg_n` stays high even if `host_br_n` and `leg_grant_n` are both low.
- R7: If the host releases `host_br_n` (sampled high) before a transaction starts, `leg_req_n` goes high after that edge.
- R8: If `leg_grant_n` goes high after the bus was won but before a start, `host_bg_n` goes high in that same cycle. The legacy request stays low and the bridge waits for the grant again. A start strobe sampled in such a cycle is ignored.
- R9: `host_ts_n` and `txn_done` have no effect while the bridge is idle: `leg_req_n` stays high on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_br_n | input | 1 | Host bus request, active low |
| host_bg_n | output | 1 | Bus grant to the host, active low |
| host_ts_n | input | 1 | Host transaction start strobe, active low |
| txn_done | input | 1 | Transaction complete, active high, one cycle |
| leg_req_n | output | 1 | Request to the legacy arbiter, active low |
| leg_grant_n | input | 1 | Grant from the legacy arbiter, active low |

## Verification
Two events can land on the same edge: the end of a transaction (`txn_done`) and a fresh host request with the legacy grant still low. When they coincide, the bridge must withhold the host grant in that cycle and release the legacy request for one cycle before asking again. Directed steps create this overlap on purpose, and the random traffic repeats it many times. A cycle-level model in the bench, written from the requirements, predicts both outputs in every cycle.

// File: rtl/arb_bridge_pkg.sv
package arb_bridge_pkg;
  // Bridge arbitration phase
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no request outstanding
    ST_ASK  = 2'd1,  // legacy request driven, waiting for grant
    ST_OWN  = 2'd2,  // bus won, host may start
    ST_BUSY = 2'd3   // transaction in flight, request stretched
  } arb_st_e;
endpackage

// File: rtl/arb_phase_fsm.sv
module arb_phase_fsm
  import arb_bridge_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    host_br_n,
  input  logic    host_ts_n,
  input  logic    txn_done,
  input  logic    leg_grant_n,
  output arb_st_e st
);

  arb_st_e st_nxt;
  logic    st_en;
  logic    start_ok;

  // a start counts only when the host actually holds the grant
  assign start_ok = (st == ST_OWN) && !leg_grant_n && !host_ts_n;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: if (!host_br_n) st_nxt = ST_ASK;
      ST_ASK: begin
        if (host_br_n)         st_nxt = ST_IDLE;
        else if (!leg_grant_n) st_nxt = ST_OWN;
      end
      ST_OWN: begin
        if (start_ok)         st_nxt = ST_BUSY;
        else if (host_br_n)   st_nxt = ST_IDLE;
        else if (leg_grant_n) st_nxt = ST_ASK;
      end
      ST_BUSY: if (txn_done) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign st_en = (st_nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= ST_IDLE;
    else if (st_en) st <= st_nxt;
  end

  // R4: a granted start always enters the stretched phase
  assert_start_enters_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OWN && !leg_grant_n && !host_ts_n) |=> (st == ST_BUSY));

  // R9: strobes seen while idle never lead into a transaction
  assert_idle_no_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> (st != ST_BUSY));

endmodule

// File: rtl/arb_out_decode.sv
module arb_out_decode
  import arb_bridge_pkg::*;
(
  input  arb_st_e st,
  input  logic    leg_grant_n,
  output logic    leg_req_n,
  output logic    host_bg_n
);

  logic req_live;
  logic grant_live;

  always_comb begin
    req_live   = (st != ST_IDLE);
    grant_live = (st == ST_OWN) && !leg_grant_n;
    leg_req_n  = !req_live;
    host_bg_n  = !grant_live;
  end

endmodule

// File: rtl/arb_req_stretcher.sv
module arb_req_stretcher
  import arb_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_br_n,
  output logic host_bg_n,
  input  logic host_ts_n,
  input  logic txn_done,
  output logic leg_req_n,
  input  logic leg_grant_n
);

  arb_st_e st;

  arb_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_br_n   (host_br_n),
    .host_ts_n   (host_ts_n),
    .txn_done    (txn_done),
    .leg_grant_n (leg_grant_n),
    .st          (st)
  );

  arb_out_decode u_dec (
    .st          (st),
    .leg_grant_n (leg_grant_n),
    .leg_req_n   (leg_req_n),
    .host_bg_n   (host_bg_n)
  );

  // R2: idle bridge forwards a sampled host request on the next cycle
  assert_req_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_req_n && !host_br_n) |=> !leg_req_n);

  // R3: a host grant needs a live legacy grant and an outstanding request
  assert_grant_backed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_bg_n |-> (!leg_grant_n && !leg_req_n));

  // R4: request held through the transaction
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY && !txn_done) |=> !leg_req_n);

  // R5: request released after the transaction ends
  assert_req_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY && txn_done) |=> leg_req_n);

  // R6: no host grant while a transaction runs
  assert_no_grant_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY) |-> host_bg_n);

endmodule

// File: tb/tb_arb_req_stretcher.sv
`timescale 1ns/1ps
module tb_arb_req_stretcher;

  logic clk;
  logic rst_n;
  logic host_br_n, host_ts_n, txn_done, leg_grant_n;
  logic host_bg_n, leg_req_n;

  int n_run;
  int n_fail;
  bit done_flag;
  int m;  // model phase: 0 idle, 1 asking, 2 owned, 3 busy

  arb_req_stretcher dut (
    .clk(clk), .rst_n(rst_n),
    .host_br_n(host_br_n), .host_bg_n(host_bg_n),
    .host_ts_n(host_ts_n), .txn_done(txn_done),
    .leg_req_n(leg_req_n), .leg_grant_n(leg_grant_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic exp_req(input int ph);
    return (ph == 0);
  endfunction

  function automatic logic exp_bg(input int ph, input logic gn);
    return !(ph == 2 && !gn);
  endfunction

  function automatic int model_next(input int ph, input logic br, input logic ts,
                                    input logic dn, input logic gn);
    case (ph)
      0: return br ? 0 : 1;
      1: return br ? 0 : (gn ? 1 : 2);
      2: begin
        if (!gn && !ts) return 3;
        if (br) return 0;
        if (gn) return 1;
        return 2;
      end
      default: return dn ? 0 : 3;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic br, input logic ts, input logic dn, input logic gn,
                     input string tag);
    @(negedge clk);
    host_br_n = br; host_ts_n = ts; txn_done = dn; leg_grant_n = gn;
    #1;
    check(leg_req_n, exp_req(m), tag, "leg_req_n");
    check(host_bg_n, exp_bg(m, gn), tag, "host_bg_n");
    @(posedge clk);
    m = model_next(m, br, ts, dn, gn);
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; m = 0; done_flag = 0;
    host_br_n = 1'b0; host_ts_n = 1'b0; txn_done = 1'b1; leg_grant_n = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(leg_req_n, 1'b1, "R1", "leg_req_n in reset");
    check(host_bg_n, 1'b1, "R1", "host_bg_n in reset");
    host_br_n = 1'b1; host_ts_n = 1'b1; txn_done = 1'b0; leg_grant_n = 1'b1;
    rst_n = 1'b1;
    m = 0;
    cyc(1, 1, 0, 1, "R1");
    // request, grant, start
    cyc(0, 1, 0, 1, "R2");
    cyc(0, 1, 0, 1, "R2");
    cyc(0, 1, 0, 0, "R3");
    cyc(0, 0, 0, 0, "R3");
    // host lets request go mid-transaction; new request held off
    cyc(1, 1, 0, 0, "R4");
    cyc(1, 1, 0, 0, "R4");
    cyc(0, 1, 0, 0, "R6");
    cyc(0, 1, 0, 0, "R6");
    // end coincides with a fresh request under a live grant
    cyc(0, 1, 1, 0, "R5");
    cyc(0, 1, 0, 0, "R5");
    cyc(0, 1, 0, 0, "R5");
    cyc(0, 1, 0, 0, "R3");
    // early release before start
    cyc(1, 1, 0, 1, "R7");
    cyc(1, 1, 0, 1, "R7");
    // grant revoked after win; start attempted while revoked
    cyc(0, 1, 0, 1, "R8");
    cyc(0, 1, 0, 0, "R8");
    cyc(0, 0, 0, 1, "R8");
    cyc(0, 1, 0, 1, "R8");
    cyc(1, 1, 0, 1, "R7");
    // strobes while idle
    cyc(1, 0, 1, 0, "R9");
    cyc(1, 1, 0, 0, "R9");
    cyc(1, 1, 0, 0, "R9");
    // random traffic
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic br, ts, dn, gn;
      br = ($urandom_range(99) < 35);
      ts = ($urandom_range(99) < 60);
      dn = ($urandom_range(99) < 25);
      gn = (m != 0) ? ($urandom_range(99) < 30) : ($urandom_range(99) < 70);
      cyc(br, ts, dn, gn, (m == 3) ? "R4" : ((m == 2) ? "R3" : "R2"));
    end
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule